// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames from a byte stream into memory buffers owned by a ring of receive descriptors. Software prepares the ring, marks data descriptors as available and points a base table entry at the ring. When receive is enabled, the engine finds the ring through that table. It claims the next available buffer and stores each incoming byte at consecutive byte addresses. At the end of the frame it returns the descriptor with the stored length, the status flags and a new type code. It then follows the slot's link descriptor to the next slot.

The frame input has no back-pressure, so the engine fetches the next descriptor before a frame arrives. A frame that begins while no buffer is claimed is discarded as a whole and counted. CRC checking, framing checks and multicast classification happen upstream and reach the block as flags with the last byte.

Memory layout (byte addresses, 32-bit little-endian words): a descriptor is two words, a control word at +0 and a pointer at +4. A ring slot is 16 bytes: a data descriptor at +0 and a link descriptor at +8, whose pointer (slot+12) holds the address of the next slot. In a control word, bits 31:28 are the type and bits 11:0 are a byte count.

Top module: `rx_desc_writer`

## Requirements
- R1: After reset, and while rx_en stays low, the block makes no memory read or write and drop_cnt is 0.
- R2: When rx_en rises, the first memory read is the word at base_addr + 0x24, the pointer of base table entry 4. That word is the address of the first ring slot. Every read address is word aligned.
- R3: A data descriptor is claimed only when its control bits 31:28 equal 0xC. Its bits 11:0 are then taken as the buffer capacity and the word at slot+4 as the buffer address. Frame byte k is written to buffer address + k with a single byte strobe, mem_be bit (address mod 4). The byte is replicated in all four data lanes.
- R4: One cycle after the last byte is written, the control word at the slot address is written with all four strobes. Bits 31:28 are 0x7, bits 11:0 hold the stored byte count, and bits 27:24, 21:20 and 15:12 are zero.
- R5: Bit 18 of the returned control word is set when the frame had fewer than 64 bytes. A frame of exactly 64 bytes leaves it clear.
- R6: rx_flags, sampled with the last byte, map into the returned word as follows: bit 0 (CRC error) to bit 16, bit 1 (framing error) to bit 17, bit 2 (carrier extension error) to bit 22, and bit 3 (multicast) to bit 23.
- R7: Bytes beyond the buffer capacity are not written. Bit 19 is then set and the stored count equals the capacity, and the descriptor is still returned.
- R8: No more than 1518 bytes of a frame are stored. A longer frame returns a count of 1518 with bit 19 set.
- R9: A frame whose first byte arrives while rx_en is high but no buffer is claimed causes no memory write. drop_cnt rises by exactly one.
- R10: A data descriptor that is not available is re-read until it becomes available. It is then used for the next frame.
- R11: After returning a descriptor the engine reads slot+12 and continues at that address, so a ring whose last link points at the first slot wraps around.
- R12: While rx_en is low, after any frame in progress has finished, incoming frames cause no write and are not counted. Raising rx_en again restarts from the base table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| base_addr | input | 32 | Byte address of the descriptor base table |
| rx_valid | input | 1 | A frame byte is present on rx_data |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_flags | input | 4 | Frame status, valid with rx_last: {multicast, carrier ext err, framing err, CRC err} |
| mem_rd | output | 1 | Memory read request; data returns on mem_rdata the next cycle |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Byte strobes for a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| drop_cnt | output | 16 | Number of frames dropped for lack of a buffer |

## Verification
A wrong slot or buffer pointer shows up at the first byte write of the next frame, which goes to an address the reference model does not expect. A wrong byte counter or status flag shows up at the single control-word write one cycle after the last byte. A fault in drop detection shows on drop_cnt the cycle after the first byte of a frame that should, or should not, have been discarded. The bench compares every memory write and drop_cnt against its model on every clock, so any such divergence is seen within one frame.

// File: rtl/rx_desc_writer.sv
module rx_desc_writer #(
  parameter int AW       = 32,
  parameter int MAX_LEN  = 1518,
  parameter int MIN_LEN  = 64,
  parameter int BASE_IDX = 4,
  parameter int DCW      = 16,
  parameter int TW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic [AW-1:0] base_addr,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic [3:0]    rx_flags,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [DCW-1:0] drop_cnt
);
  localparam logic [3:0]    T_FREE   = 4'hC;
  localparam logic [3:0]    T_FULL   = 4'h7;
  localparam logic [AW-1:0] OFF_BASE = AW'(BASE_IDX * 8 + 4);
  localparam logic [AW-1:0] OFF_PTR  = AW'(4);
  localparam logic [AW-1:0] OFF_LINK = AW'(12);
  localparam logic [11:0]   MAX12    = 12'(MAX_LEN);

  typedef enum logic [3:0] {
    S_IDLE, S_BASE, S_BASE_W, S_CTRL, S_CTRL_W, S_PTR, S_PTR_W,
    S_READY, S_RECV, S_FIN, S_WB, S_LINK, S_LINK_W
  } st_t;

  st_t           st;
  logic [AW-1:0] slot, bufp, baddr;
  logic [11:0]   cap, stored;
  logic [TW-1:0] total;
  logic [3:0]    fl;
  logic          long_f, in_frm, bvld;
  logic [7:0]    bdat;

  wire        sof      = rx_valid && !in_frm;
  wire [11:0] lim      = (cap < MAX12) ? cap : MAX12;
  wire        take_sof = sof && rx_en && (st == S_READY);
  wire        busy     = (st == S_RECV) || (st == S_FIN) || (st == S_WB);
  wire        short_f  = total < TW'(MIN_LEN);
  wire [31:0] wb_word  = {T_FULL, 4'h0, fl[3], fl[2], 2'b00, long_f, short_f,
                          fl[1], fl[0], 4'h0, stored};
  wire        unused_ctrl_bits = ^mem_rdata[27:12];

  assign mem_rd    = (st == S_BASE) || (st == S_CTRL) || (st == S_PTR) || (st == S_LINK);
  assign mem_wr    = bvld || (st == S_WB);
  assign mem_addr  = bvld            ? baddr :
                     (st == S_BASE)  ? base_addr + OFF_BASE :
                     (st == S_PTR)   ? slot + OFF_PTR :
                     (st == S_LINK)  ? slot + OFF_LINK : slot;
  assign mem_be    = bvld ? (4'b0001 << baddr[1:0]) : ((st == S_WB) ? 4'hF : 4'h0);
  assign mem_wdata = bvld ? {4{bdat}} : wb_word;

  always_ff @(posedge clk) begin
    if (!rst_n) in_frm <= 1'b0;
    else if (rx_valid) in_frm <= !rx_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) drop_cnt <= '0;
    else if (sof && rx_en && st != S_READY) drop_cnt <= drop_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; slot <= '0; bufp <= '0; baddr <= '0; cap <= '0;
      stored <= '0; total <= '0; fl <= '0; long_f <= 1'b0; bvld <= 1'b0; bdat <= '0;
    end else begin
      bvld <= 1'b0;
      if (!rx_en && !busy) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE:   st <= S_BASE;
          S_BASE:   st <= S_BASE_W;
          S_BASE_W: begin slot <= AW'(mem_rdata); st <= S_CTRL; end
          S_CTRL:   st <= S_CTRL_W;
          S_CTRL_W: begin
            if (mem_rdata[31:28] == T_FREE) begin
              cap <= mem_rdata[11:0];
              st  <= S_PTR;
            end else begin
              st <= S_CTRL;
            end
          end
          S_PTR:    st <= S_PTR_W;
          S_PTR_W:  begin bufp <= AW'(mem_rdata); st <= S_READY; end
          S_READY: begin
            if (take_sof) begin
              stored <= (lim != 12'd0) ? 12'd1 : 12'd0;
              long_f <= (lim == 12'd0);
              total  <= TW'(1);
              bvld   <= (lim != 12'd0);
              baddr  <= bufp;
              bdat   <= rx_data;
              if (rx_last) begin fl <= rx_flags; st <= S_FIN; end
              else st <= S_RECV;
            end
          end
          S_RECV: begin
            if (rx_valid) begin
              if (stored < lim) begin
                bvld   <= 1'b1;
                baddr  <= bufp + AW'(stored);
                bdat   <= rx_data;
                stored <= stored + 12'd1;
              end else begin
                long_f <= 1'b1;
              end
              if (!(&total)) total <= total + 1'b1;
              if (rx_last) begin fl <= rx_flags; st <= S_FIN; end
            end
          end
          S_FIN:    st <= S_WB;
          S_WB:     st <= S_LINK;
          S_LINK:   st <= S_LINK_W;
          S_LINK_W: begin slot <= AW'(mem_rdata); st <= S_CTRL; end
          default:  st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_desc_writer_props.sv
module rx_desc_writer_props #(
  parameter int MAX_LEN = 1518
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic [15:0] drop_cnt
);
  AST_RD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[1:0] == 2'b00)); // R2

  AST_STROBE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($countones(mem_be) == 1 || mem_be == 4'hF)); // R3

  AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R3

  AST_WB_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_be == 4'hF) |-> (mem_wdata[31:28] == 4'h7)); // R4

  AST_WB_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_be == 4'hF) |-> (mem_wdata[11:0] <= 12'(MAX_LEN))); // R8

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + 16'd1)); // R9
endmodule

bind rx_desc_writer rx_desc_writer_props u_props (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .drop_cnt(drop_cnt)
);

// File: tb/sim_rx_desc_writer.sv
`timescale 1ns/1ps
module sim_rx_desc_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic [31:0] base_addr = 32'h0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h0;
  logic        rx_last = 1'b0;
  logic [3:0]  rx_flags = 4'h0;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = 32'h0;
  logic [15:0] drop_cnt;

  always #2.5 clk = ~clk;

  rx_desc_writer u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .base_addr(base_addr),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_flags(rx_flags),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .drop_cnt(drop_cnt)
  );

  typedef struct { logic [31:0] a; logic [3:0] be; logic [31:0] d; } wr_t;
  wr_t         expq[$];
  logic [31:0] mem [int];
  int          nchk = 0, nfail = 0, cyc = 0, exp_drop = 0, mslot = 0;
  int          capv [8];
  bit          got_first = 0, done = 0;
  logic [31:0] first_rd = 32'h0;

  function automatic logic [31:0] rdw(logic [31:0] a);
    return mem.exists(int'(a >> 2)) ? mem[int'(a >> 2)] : 32'h0;
  endfunction
  function automatic logic [31:0] slot_addr(int i); return 32'h100 + 32'(16 * i); endfunction
  function automatic logic [31:0] buf_addr(int i);  return 32'h1000 + 32'(2048 * i); endfunction
  function automatic logic [31:0] lane_mask(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_wr) begin
      logic [31:0] w;
      w = rdw(mem_addr);
      for (int k = 0; k < 4; k++) if (mem_be[k]) w[8*k +: 8] = mem_wdata[8*k +: 8];
      mem[int'(mem_addr >> 2)] = w;
    end
    if (mem_rd) mem_rdata <= rdw(mem_addr);
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 drop_cnt", 32'(drop_cnt), 32'(exp_drop));
      if (mem_rd && !got_first) begin got_first = 1; first_rd = mem_addr; end
      if (mem_wr) begin
        if (expq.size() == 0) begin
          chk("R9 R12 unexpected write addr", mem_addr, 32'hFFFF_FFFF);
        end else begin
          wr_t e;
          e = expq.pop_front();
          chk(e.be == 4'hF ? "R4 wb addr" : "R3 byte addr", mem_addr, e.a);
          chk(e.be == 4'hF ? "R4 wb strobe" : "R3 byte strobe", 32'(mem_be), 32'(e.be));
          chk(e.be == 4'hF ? "R4 wb data" : "R3 byte data", mem_wdata & lane_mask(e.be), e.d);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic set_slot(int i, logic [3:0] typ, int c);
    mem[int'(slot_addr(i) >> 2)] = {typ, 16'h0, 12'(c)};
    capv[i] = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(int n, logic [3:0] fl, bit acc, logic [7:0] seed, string tag);
    logic [31:0] ctrl;
    int lim, st;
    if (acc) begin
      lim = (capv[mslot] < 1518) ? capv[mslot] : 1518;
      st  = (n < lim) ? n : lim;
      for (int b = 0; b < n; b++)
        if (b < lim) begin
          wr_t e;
          e.a = buf_addr(mslot) + 32'(b);
          e.be = 4'b0001 << (b % 4);
          e.d = 32'(8'(seed + b)) << (8 * (b % 4));
          expq.push_back(e);
        end
      ctrl = {4'h7, 4'h0, fl[3], fl[2], 2'b00, (n > lim), (n < 64), fl[1], fl[0], 4'h0, 12'(st)};
      begin
        wr_t e;
        e.a = slot_addr(mslot); e.be = 4'hF; e.d = ctrl;
        expq.push_back(e);
      end
    end
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = 8'(seed + b);
      rx_last  = (b == n - 1);
      rx_flags = (b == n - 1) ? fl : 4'h0;
      if (b == 0 && !acc && rx_en) begin
        @(posedge clk);
        #1 exp_drop++;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_flags = 4'h0;
    idle(20);
    if (acc) begin
      chk(tag, rdw(slot_addr(mslot)), ctrl);
      chk({tag, " pending writes"}, 32'(expq.size()), 32'h0);
      mslot = (mslot + 1) % 8;
    end
  endtask

  initial begin
    mem[int'(32'h20 >> 2)] = 32'h9000_0000;
    mem[int'(32'h24 >> 2)] = slot_addr(0);
    for (int i = 0; i < 8; i++) begin
      set_slot(i, 4'hC, 1536);
      mem[int'((slot_addr(i) + 4) >> 2)]  = buf_addr(i);
      mem[int'((slot_addr(i) + 8) >> 2)]  = 32'h9000_0000;
      mem[int'((slot_addr(i) + 12) >> 2)] = slot_addr((i + 1) % 8);
    end
    set_slot(3, 4'hC, 32);
    set_slot(5, 4'h3, 1536);
    idle(5);
    rst_n = 1'b1;
    idle(5);
    chk("R1 mem_rd idle", 32'(mem_rd), 0);
    chk("R1 mem_wr idle", 32'(mem_wr), 0);
    chk("R1 drop_cnt reset", 32'(drop_cnt), 0);
    chk("R1 no read while disabled", 32'(got_first), 0);

    rx_en = 1'b1;
    idle(20);
    chk("R2 first read at base entry 4", first_rd, 32'h24);

    send(70,   4'b0000, 1, 8'h10, "R4 plain frame");
    send(40,   4'b0000, 1, 8'h20, "R5 short frame");
    send(64,   4'b1001, 1, 8'h30, "R6 crc+mcast, R5 exact 64");
    send(80,   4'b0000, 1, 8'h40, "R7 truncated to capacity");
    send(1530, 4'b0000, 1, 8'h50, "R8 max length clamp");

    send(30, 4'b0000, 0, 8'h60, "R9 drop");
    chk("R9 one frame dropped", 32'(drop_cnt), 1);
    set_slot(5, 4'hC, 1536);
    set_slot(0, 4'hC, 1536);
    idle(10);
    send(65,  4'b0000, 1, 8'h70, "R10 slot freed while polling");
    send(100, 4'b0110, 1, 8'h80, "R6 framing+carrier ext");
    send(1,   4'b0000, 1, 8'h90, "R5 single byte frame");
    send(200, 4'b0000, 1, 8'hA0, "R11 ring wrap to first slot");

    rx_en = 1'b0;
    idle(10);
    got_first = 0;
    send(50, 4'b0000, 0, 8'hB0, "R12 disabled");
    chk("R12 no drop count while disabled", 32'(drop_cnt), 1);
    chk("R12 no read while disabled", 32'(got_first), 0);
    for (int i = 0; i < 8; i++) set_slot(i, 4'hC, 1536);
    mslot = 0;
    rx_en = 1'b1;
    idle(20);
    chk("R12 restart from base table", first_rd, 32'h24);
    send(64, 4'b0000, 1, 8'hC0, "R12 first frame after restart");

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule